// File: doc/BRIEF.md
# Multimode Quadrature Position Counter (single axis)

This block is one axis of an incremental-encoder position counter. It turns two encoder phase inputs into count pulses and a direction. The phases can be decoded at one, two or four counts per encoder cycle, or they can be read as a step input plus a direction level. The pulses drive a position counter whose working width is 8, 16 or 24 bits. A range mode chooses what happens at the ends of the range: the counter can wrap freely, wrap at a programmed modulus, stop and freeze after the first overflow, or clamp at its ends.

A preset register holds the modulus or clamp limit. It can also be copied into the counter. A snapshot register captures the count when commanded. An equality comparator flags when the counter equals the preset. A live status word follows carry, borrow, match, direction and the freeze state. A held status word takes a copy of the live word on command and also keeps sticky carry, borrow and match flags, which only a clear can remove. A rising edge on the index input performs one programmable action. Registers are written through a simple strobe with a select code, and they are read directly at the output ports. The encoder inputs are expected to arrive already filtered and synchronous to the clock.

Top module: `qcnt_axis`

## Requirements
- R1: After reset, the count, snapshot, preset, mode0 and mode1 all read 0. The live status shows only its match bit (live = 5'b00100, because count 0 equals preset 0).
- R2: With mode0[1:0]=3, each change of exactly one phase input moves the count by one, one clock edge after the change. Counting goes up when {A,B} steps through 00,10,11,01 and down when it steps the reverse way.
- R3: With mode0[1:0]=2, only edges of A count. The count goes up when A differs from B after the edge and down otherwise. A change of B alone leaves the count unchanged.
- R4: With mode0[1:0]=1, there is one count per encoder cycle: up on a rising edge of A while B is 0, and down on a falling edge of A while B is 0. No other edge counts.
- R5: With mode0[1:0]=0, a rising edge of A counts up when B is 1 and down when B is 0. A falling edge of A and any change of B have no effect.
- R6: mode1[1:0] selects the working width: 0 for 8 bits, 1 for 16 bits, 2 or 3 for 24 bits. The count, the snapshot and the limit (preset masked to the width) all follow it. With mode0[3:2]=0 (free-run), up from the all-ones value wraps to 0 and sets live bit0 (carry). Down from 0 wraps to all-ones and sets live bit1 (borrow).
- R7: With mode0[3:2]=2 (modulus), up from the limit N (or above it) goes to 0 with carry. Down from 0 goes to N with borrow.
- R8: With mode0[3:2]=1 (one-shot), a step that would wrap leaves the count unchanged and sets carry or borrow together with live bit4 (frozen). While frozen, no step has any effect until the counter is loaded or zeroed.
- R9: With mode0[3:2]=3 (clamp), up at or above N holds the count and sets carry. Down at 0 holds the count and sets borrow. The counter can always reverse.
- R10: Live bit2 (match) is 1 exactly when the count equals the limit. Live bit3 gives the direction of the last accepted step (1 means up). Every accepted step replaces carry and borrow with the result of that step.
- R11: Write select 0 writes mode0[6:0], select 1 writes mode1[1:0] and select 2 writes the preset; a preset write does not change the count. cmd_snap copies the count to the snapshot. cmd_load copies the limit into the count. cmd_zero clears the count. Both load and zero also clear carry, borrow and frozen. Zero takes priority over load, and load takes priority over a step in the same cycle.
- R12: cmd_stlatch copies the live word into held[4:0]. held[5], held[6] and held[7] become sticky carry, borrow and match, one cycle after the live bit is seen. cmd_stclr clears the sticky bits and the live carry and borrow, and it is the only thing that removes sticky bits.
- R13: A rising edge of the index input performs the action in mode0[6:4]: 1 loads, 2 zeroes, 3 takes a snapshot, 4 clears status as cmd_stclr does, and 5 latches status. Codes 0, 6 and 7 do nothing. Holding the index high repeats no action, and counting continues normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_a | input | 1 | Phase A, or the step input in step/direction mode |
| in_b | input | 1 | Phase B, or the direction level in step/direction mode |
| in_idx | input | 1 | Index input; its rising edge triggers the programmed action |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode0, 1 mode1, 2 preset, 3 none |
| wr_data | input | CNT_W | Write data |
| cmd_snap | input | 1 | Copy count into snapshot |
| cmd_load | input | 1 | Load limit into count |
| cmd_zero | input | 1 | Clear count |
| cmd_stlatch | input | 1 | Copy live status into held[4:0] |
| cmd_stclr | input | 1 | Clear sticky bits and live carry/borrow |
| mode0_o | output | 7 | Resolution [1:0], range [3:2], index action [6:4] |
| mode1_o | output | 2 | Width select |
| preset_o | output | CNT_W | Preset register |
| count_o | output | CNT_W | Counter, masked to the working width |
| snap_o | output | CNT_W | Snapshot register |
| live_o | output | 5 | Live status {frozen, up, match, borrow, carry} |
| held_o | output | 8 | Held status {sticky match, borrow, carry, latched live copy} |

## Verification
The bench builds the block with its default CNT_W of 24, so all three widths can be reached. The sweep runs in the 8-bit width, where a modest number of steps crosses both wrap points. It covers every pairing of the four decoding resolutions with the four range modes. Each pairing walks the phase inputs forward and then backward from a loaded start value close to a range end. Every input change is checked against an arithmetic model of the count and the live flags. Directed sequences then cover the 16- and 24-bit wrap points, command priority, status latching and sticky behaviour, and each index action.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

    typedef enum logic [1:0] {
        RES_STEPDIR = 2'd0,
        RES_X1      = 2'd1,
        RES_X2      = 2'd2,
        RES_X4      = 2'd3
    } res_e;

    typedef enum logic [1:0] {
        RNG_FREE    = 2'd0,
        RNG_ONESHOT = 2'd1,
        RNG_MODN    = 2'd2,
        RNG_CLAMP   = 2'd3
    } rng_e;

    typedef enum logic [2:0] {
        IDX_NONE    = 3'd0,
        IDX_LOAD    = 3'd1,
        IDX_ZERO    = 3'd2,
        IDX_SNAP    = 3'd3,
        IDX_STCLR   = 3'd4,
        IDX_STLATCH = 3'd5,
        IDX_RSV6    = 3'd6,
        IDX_RSV7    = 3'd7
    } idx_e;

    localparam int LIVE_W = 5;
    localparam int HELD_W = 8;

    typedef struct packed {
        logic frozen;
        logic up;
        logic match;
        logic borrow;
        logic carry;
    } live_t;

endpackage

// File: rtl/qcnt_decode.sv
module qcnt_decode
    import qcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  res_e res,
    input  logic in_a,
    input  logic in_b,
    output logic step,
    output logic up
);

    typedef struct packed {
        logic a;
        logic b;
    } ph_t;

    ph_t ph_d, ph_q;
    logic a_chg, b_chg;

    always_comb begin
        ph_d.a = in_a;
        ph_d.b = in_b;
        a_chg  = in_a ^ ph_q.a;
        b_chg  = in_b ^ ph_q.b;
        step   = 1'b0;
        up     = 1'b0;
        case (res)
            RES_X4: begin
                step = a_chg ^ b_chg;
                up   = ph_q.b ^ in_a;
            end
            RES_X2: begin
                step = a_chg;
                up   = in_a ^ in_b;
            end
            RES_X1: begin
                step = a_chg & ~in_b & ~b_chg;
                up   = in_a;
            end
            default: begin
                step = a_chg & in_a;
                up   = in_b;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

endmodule

// File: rtl/qcnt_core.sv
module qcnt_core
    import qcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             up,
    input  rng_e             rng,
    input  logic [CNT_W-1:0] mask,
    input  logic [CNT_W-1:0] lim,
    input  logic             do_zero,
    input  logic             do_load,
    input  logic             st_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             carry,
    output logic             borrow,
    output logic             dir_up,
    output logic             frozen
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             carry;
        logic             borrow;
        logic             up;
        logic             frozen;
    } core_t;

    core_t d, q;
    logic [CNT_W-1:0] cur, nxt;
    logic             c_ev, b_ev, halt, at_top;

    always_comb begin
        d      = q;
        cur    = q.cnt & mask;
        nxt    = cur;
        c_ev   = 1'b0;
        b_ev   = 1'b0;
        halt   = 1'b0;
        at_top = (rng == RNG_MODN || rng == RNG_CLAMP) ? (cur >= lim) : (cur == mask);
        if (up) begin
            if (at_top) begin
                c_ev = 1'b1;
                halt = (rng == RNG_ONESHOT);
                case (rng)
                    RNG_FREE, RNG_MODN: nxt = '0;
                    default:            nxt = cur;
                endcase
            end else begin
                nxt = (cur + 1'b1) & mask;
            end
        end else begin
            if (cur == '0) begin
                b_ev = 1'b1;
                halt = (rng == RNG_ONESHOT);
                case (rng)
                    RNG_FREE: nxt = mask;
                    RNG_MODN: nxt = lim;
                    default:  nxt = cur;
                endcase
            end else begin
                nxt = cur - 1'b1;
            end
        end

        if (do_zero) begin
            d.cnt    = '0;
            d.carry  = 1'b0;
            d.borrow = 1'b0;
            d.frozen = 1'b0;
        end else if (do_load) begin
            d.cnt    = lim;
            d.carry  = 1'b0;
            d.borrow = 1'b0;
            d.frozen = 1'b0;
        end else if (step && !q.frozen) begin
            d.cnt    = nxt;
            d.carry  = c_ev;
            d.borrow = b_ev;
            d.up     = up;
            d.frozen = halt;
        end

        if (st_clr) begin
            d.carry  = 1'b0;
            d.borrow = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt    = q.cnt & mask;
    assign carry  = q.carry;
    assign borrow = q.borrow;
    assign dir_up = q.up;
    assign frozen = q.frozen;

endmodule

// File: rtl/qcnt_status.sv
module qcnt_status
    import qcnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  live_t             live,
    input  logic              latch,
    input  logic              clr,
    output logic [HELD_W-1:0] held
);

    typedef struct packed {
        logic  s_match;
        logic  s_borrow;
        logic  s_carry;
        live_t copy;
    } held_t;

    held_t d, q;

    always_comb begin
        d = q;
        if (latch) d.copy = live;
        if (clr) begin
            d.s_carry  = 1'b0;
            d.s_borrow = 1'b0;
            d.s_match  = 1'b0;
        end else begin
            d.s_carry  = q.s_carry  | live.carry;
            d.s_borrow = q.s_borrow | live.borrow;
            d.s_match  = q.s_match  | live.match;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign held = q;

endmodule

// File: rtl/qcnt_axis.sv
module qcnt_axis
    import qcnt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_a,
    input  logic              in_b,
    input  logic              in_idx,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              cmd_snap,
    input  logic              cmd_load,
    input  logic              cmd_zero,
    input  logic              cmd_stlatch,
    input  logic              cmd_stclr,
    output logic [6:0]        mode0_o,
    output logic [1:0]        mode1_o,
    output logic [CNT_W-1:0]  preset_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  snap_o,
    output logic [LIVE_W-1:0] live_o,
    output logic [HELD_W-1:0] held_o
);

    localparam int NBYTES = CNT_W / 8;

    typedef struct packed {
        logic [6:0]       mode0;
        logic [1:0]       mode1;
        logic [CNT_W-1:0] preset;
        logic [CNT_W-1:0] snap;
        logic             idx;
    } regs_t;

    regs_t d, q;

    res_e             res;
    rng_e             rng;
    idx_e             act;
    int unsigned      act_bytes;
    logic [CNT_W-1:0] mask, lim, cnt;
    logic [NBYTES-1:0] byte_eq;
    logic             idx_rise, do_zero, do_load, do_snap, do_clr, do_latch;
    logic             step, up, carry, borrow, dir_up, frozen;
    live_t            live;

    assign res = res_e'(q.mode0[1:0]);
    assign rng = rng_e'(q.mode0[3:2]);
    assign act = idx_e'(q.mode0[6:4]);

    always_comb begin
        act_bytes = 32'(q.mode1) + 32'd1;
        if (act_bytes > NBYTES) act_bytes = NBYTES;
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign mask[8*i +: 8] = (i < act_bytes) ? 8'hFF : 8'h00;
        assign byte_eq[i]     = (cnt[8*i +: 8] == lim[8*i +: 8]);
    end

    assign lim      = q.preset & mask;
    assign idx_rise = in_idx & ~q.idx;
    assign do_zero  = cmd_zero    | (idx_rise && act == IDX_ZERO);
    assign do_load  = cmd_load    | (idx_rise && act == IDX_LOAD);
    assign do_snap  = cmd_snap    | (idx_rise && act == IDX_SNAP);
    assign do_clr   = cmd_stclr   | (idx_rise && act == IDX_STCLR);
    assign do_latch = cmd_stlatch | (idx_rise && act == IDX_STLATCH);

    always_comb begin
        d     = q;
        d.idx = in_idx;
        if (wr_en) begin
            case (wr_sel)
                2'd0:    d.mode0  = wr_data[6:0];
                2'd1:    d.mode1  = wr_data[1:0];
                2'd2:    d.preset = wr_data;
                default: ;
            endcase
        end
        if (do_snap) d.snap = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    qcnt_decode u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .res   (res),
        .in_a  (in_a),
        .in_b  (in_b),
        .step  (step),
        .up    (up)
    );

    qcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .up      (up),
        .rng     (rng),
        .mask    (mask),
        .lim     (lim),
        .do_zero (do_zero),
        .do_load (do_load),
        .st_clr  (do_clr),
        .cnt     (cnt),
        .carry   (carry),
        .borrow  (borrow),
        .dir_up  (dir_up),
        .frozen  (frozen)
    );

    always_comb begin
        live.carry  = carry;
        live.borrow = borrow;
        live.match  = &byte_eq;
        live.up     = dir_up;
        live.frozen = frozen;
    end

    qcnt_status u_st (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live),
        .latch (do_latch),
        .clr   (do_clr),
        .held  (held_o)
    );

    assign mode0_o  = q.mode0;
    assign mode1_o  = q.mode1;
    assign preset_o = q.preset;
    assign count_o  = cnt;
    assign snap_o   = q.snap & mask;
    assign live_o   = live;

endmodule

// File: rtl/qcnt_axis_chk.sv
module qcnt_axis_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             cmd_snap,
    input logic             cmd_load,
    input logic             cmd_zero,
    input logic             cmd_stclr,
    input logic [6:0]       mode0_o,
    input logic [1:0]       mode1_o,
    input logic [CNT_W-1:0] preset_o,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] snap_o,
    input logic [4:0]       live_o,
    input logic [7:0]       held_o
);

    logic [CNT_W-1:0] wmask;

    always_comb begin
        wmask = '0;
        for (int i = 0; i < CNT_W; i++) begin
            if (mode1_o == 2'd0) wmask[i] = (i < 8);
            else if (mode1_o == 2'd1) wmask[i] = (i < 16);
            else wmask[i] = 1'b1;
        end
    end

    assert_count_in_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o & ~wmask) == '0);

    assert_match_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        live_o[2] == (count_o == (preset_o & wmask)));

    assert_carry_borrow_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(live_o[0] && live_o[1]));

    assert_zero_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_zero |=> count_o == '0);

    assert_load_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !cmd_zero && !wr_en) |=> count_o == $past(preset_o & wmask));

    assert_snap_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_snap && !wr_en) |=> snap_o == $past(count_o));

    assert_frozen_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_o[4] && !cmd_zero && !cmd_load && !wr_en &&
         mode0_o[6:4] != 3'd1 && mode0_o[6:4] != 3'd2) |=> $stable(count_o));

    assert_sticky_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_stclr && mode0_o[6:4] != 3'd4) |=>
        ((held_o[7:5] & $past(held_o[7:5])) == $past(held_o[7:5])));

endmodule

bind qcnt_axis qcnt_axis_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .cmd_snap  (cmd_snap),
    .cmd_load  (cmd_load),
    .cmd_zero  (cmd_zero),
    .cmd_stclr (cmd_stclr),
    .mode0_o   (mode0_o),
    .mode1_o   (mode1_o),
    .preset_o  (preset_o),
    .count_o   (count_o),
    .snap_o    (snap_o),
    .live_o    (live_o),
    .held_o    (held_o)
);

// File: tb/qcnt_axis_test.sv
module qcnt_axis_test;

    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd3;
    logic [W-1:0] wr_data = '0;
    logic         cmd_snap = 1'b0, cmd_load = 1'b0, cmd_zero = 1'b0;
    logic         cmd_stlatch = 1'b0, cmd_stclr = 1'b0;
    logic [6:0]   mode0_o;
    logic [1:0]   mode1_o;
    logic [W-1:0] preset_o, count_o, snap_o;
    logic [4:0]   live_o;
    logic [7:0]   held_o;

    always #10 clk = ~clk;

    qcnt_axis #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_snap(cmd_snap), .cmd_load(cmd_load), .cmd_zero(cmd_zero),
        .cmd_stlatch(cmd_stlatch), .cmd_stclr(cmd_stclr),
        .mode0_o(mode0_o), .mode1_o(mode1_o), .preset_o(preset_o),
        .count_o(count_o), .snap_o(snap_o), .live_o(live_o), .held_o(held_o)
    );

    int n_run = 0, n_fail = 0;

    int           m_res = 0, m_rng = 0, m_size = 0;
    logic [W-1:0] m_cnt = '0, m_preset = '0, m_mask = 24'hFF;
    logic         m_carry = 0, m_borrow = 0, m_up = 0, m_frozen = 0;
    logic         pa = 0, pb = 0;
    string        res_tag [4] = '{"R5", "R4", "R3", "R2"};
    string        rng_tag [4] = '{"R6", "R8", "R7", "R9"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] m_lim();
        return m_preset & m_mask;
    endfunction

    function automatic logic [4:0] m_live();
        return {m_frozen, m_up, (m_cnt == m_lim()), m_borrow, m_carry};
    endfunction

    function automatic int phase(input logic a, input logic b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    function automatic void decode(input logic na, input logic nb, output logic st, output logic up);
        int po, pn;
        po = phase(pa, pb);
        pn = phase(na, nb);
        st = 1'b0;
        up = 1'b0;
        case (m_res)
            3: begin
                st = (pn == ((po + 1) % 4)) || (po == ((pn + 1) % 4));
                up = (pn == ((po + 1) % 4));
            end
            2: begin
                st = (pa != na);
                up = (pn == ((po + 1) % 4));
            end
            1: begin
                st = (pa != na) && !nb && !pb;
                up = na;
            end
            default: begin
                st = !pa && na;
                up = nb;
            end
        endcase
    endfunction

    function automatic void model_step(input logic up);
        logic [W-1:0] lim;
        logic         top;
        lim = m_lim();
        if (m_frozen) return;
        m_carry  = 1'b0;
        m_borrow = 1'b0;
        m_up     = up;
        if (up) begin
            top = (m_rng >= 2) ? (m_cnt >= lim) : (m_cnt == m_mask);
            if (top) begin
                m_carry = 1'b1;
                if (m_rng == 0 || m_rng == 2) m_cnt = '0;
                if (m_rng == 1) m_frozen = 1'b1;
            end else m_cnt = m_cnt + 1;
        end else begin
            if (m_cnt == 0) begin
                m_borrow = 1'b1;
                if (m_rng == 0) m_cnt = m_mask;
                if (m_rng == 2) m_cnt = lim;
                if (m_rng == 1) m_frozen = 1'b1;
            end else m_cnt = m_cnt - 1;
        end
    endfunction

    task automatic apply_ab(input logic na, input logic nb, input string req);
        logic st, up;
        decode(na, nb, st, up);
        in_a = na;
        in_b = nb;
        @(negedge clk);
        pa = na;
        pb = nb;
        if (st) model_step(up);
        chk({req, " count"}, 32'(count_o), 32'(m_cnt));
        chk({req, " live"}, 32'(live_o), 32'(m_live()));
    endtask

    task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3;
    endtask

    task automatic set_mode(input int res, input int rng, input int act, input int size);
        wr(2'd0, W'({3'(act), 2'(rng), 2'(res)}));
        wr(2'd1, W'(size));
        m_res = res; m_rng = rng; m_size = size;
        m_mask = (size == 0) ? 24'hFF : (size == 1) ? 24'hFFFF : 24'hFFFFFF;
        m_cnt  = m_cnt & m_mask;
    endtask

    task automatic set_preset(input logic [W-1:0] v);
        wr(2'd2, v);
        m_preset = v;
    endtask

    task automatic do_load();
        cmd_load = 1'b1; @(negedge clk); cmd_load = 1'b0;
        m_cnt = m_lim(); m_carry = 0; m_borrow = 0; m_frozen = 0;
    endtask

    task automatic do_zero();
        cmd_zero = 1'b1; @(negedge clk); cmd_zero = 1'b0;
        m_cnt = '0; m_carry = 0; m_borrow = 0; m_frozen = 0;
    endtask

    task automatic do_stclr();
        cmd_stclr = 1'b1; @(negedge clk); cmd_stclr = 1'b0;
        m_carry = 0; m_borrow = 0;
    endtask

    task automatic idx_pulse();
        in_idx = 1'b1; @(negedge clk); in_idx = 1'b0; @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int ph;
        logic [4:0] lv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", 32'(count_o), 0);
        chk("R1 snap", 32'(snap_o), 0);
        chk("R1 preset", 32'(preset_o), 0);
        chk("R1 mode0", 32'(mode0_o), 0);
        chk("R1 mode1", 32'(mode1_o), 0);
        chk("R1 live", 32'(live_o), 32'h04);

        // Sweep: every resolution x every range mode, 8-bit width
        ph = 0;
        for (int r = 0; r < 4; r++) begin
            for (int g = 0; g < 4; g++) begin
                set_mode(r, g, 0, 0);
                set_preset((g >= 2) ? 24'd6 : 24'd250);
                do_load();
                for (int k = 0; k < 74; k++) begin
                    ph = (k < 26) ? ((ph + 1) % 4) : ((ph + 3) % 4);
                    apply_ab(ph == 1 || ph == 2, ph >= 2, {res_tag[r], " ", rng_tag[g]});
                end
            end
        end

        // R3: B alone has no effect in X2
        set_mode(2, 0, 0, 0);
        do_zero();
        apply_ab(in_a, ~in_b, "R3 b-only");
        apply_ab(in_a, ~in_b, "R3 b-only");

        // R5: step/direction, falling A and B changes ignored
        set_mode(0, 0, 0, 0);
        do_zero();
        apply_ab(1'b0, 1'b1, "R5 dir");
        apply_ab(1'b1, 1'b1, "R5 up");
        apply_ab(1'b0, 1'b1, "R5 fall");
        apply_ab(1'b0, 1'b0, "R5 dir");
        apply_ab(1'b1, 1'b0, "R5 down");
        apply_ab(1'b0, 1'b0, "R5 fall");
        chk("R5 net", 32'(count_o), 0);

        // R6: 16-bit and 24-bit wrap points
        set_mode(0, 0, 0, 1);
        set_preset(24'h00FFFE);
        do_load();
        apply_ab(1'b0, 1'b1, "R6 16b");
        apply_ab(1'b1, 1'b1, "R6 16b");
        apply_ab(1'b0, 1'b1, "R6 16b");
        apply_ab(1'b1, 1'b1, "R6 16b wrap");
        chk("R6 16b carry", 32'(live_o[0]), 1);
        set_mode(0, 0, 0, 3);
        set_preset(24'hFFFFFF);
        do_load();
        apply_ab(1'b0, 1'b1, "R6 24b");
        apply_ab(1'b1, 1'b1, "R6 24b wrap");
        chk("R6 24b zero", 32'(count_o), 0);
        apply_ab(1'b0, 1'b0, "R6 24b");
        apply_ab(1'b1, 1'b0, "R6 24b borrow");
        chk("R6 24b max", 32'(count_o), 32'hFFFFFF);
        set_mode(0, 0, 0, 0);
        set_preset(24'h001234);
        do_load();
        chk("R6 8b mask", 32'(count_o), 32'h34);
        chk("R10 8b match", 32'(live_o[2]), 1);

        // R11: commands, priority, preset write leaves count alone
        cmd_snap = 1'b1; @(negedge clk); cmd_snap = 1'b0;
        chk("R11 snap", 32'(snap_o), 32'h34);
        set_preset(24'h000077);
        chk("R11 preset write", 32'(count_o), 32'h34);
        cmd_zero = 1'b1; cmd_load = 1'b1; @(negedge clk);
        cmd_zero = 1'b0; cmd_load = 1'b0;
        m_cnt = '0;
        chk("R11 zero over load", 32'(count_o), 0);
        apply_ab(1'b0, 1'b1, "R11 setup");
        cmd_load = 1'b1; in_a = 1'b1; @(negedge clk);
        cmd_load = 1'b0; pa = 1'b1; pb = 1'b1;
        m_cnt = m_lim(); m_carry = 0; m_borrow = 0; m_frozen = 0;
        chk("R11 load over step", 32'(count_o), 32'h77);

        // R12: latch and sticky flags
        set_preset(24'h000010);
        do_zero();
        do_stclr();
        @(negedge clk);
        chk("R12 cleared", 32'(held_o), 0);
        apply_ab(1'b0, 1'b0, "R12");
        apply_ab(1'b1, 1'b0, "R12 borrow");
        apply_ab(1'b0, 1'b1, "R12");
        apply_ab(1'b1, 1'b1, "R12 carry");
        @(negedge clk);
        chk("R12 sticky", 32'(held_o), 32'h60);
        cmd_stlatch = 1'b1; @(negedge clk); cmd_stlatch = 1'b0;
        chk("R12 latch", 32'(held_o), 32'h69);
        do_stclr();
        @(negedge clk);
        chk("R12 clear", 32'(held_o), 32'h09);
        chk("R12 live after clear", 32'(live_o), 32'h08);

        // R13: index actions
        set_preset(24'h000020);
        do_zero();
        set_mode(0, 0, 1, 0);
        idx_pulse();
        chk("R13 load", 32'(count_o), 32'h20);
        set_mode(0, 0, 2, 0);
        idx_pulse();
        chk("R13 zero", 32'(count_o), 0);
        set_preset(24'h000021);
        do_load();
        set_mode(0, 0, 3, 0);
        idx_pulse();
        chk("R13 snap", 32'(snap_o), 32'h21);
        set_mode(0, 0, 5, 0);
        lv = live_o;
        idx_pulse();
        chk("R13 latch", 32'(held_o[4:0]), 32'(lv));
        set_preset(24'h000040);
        set_mode(0, 0, 4, 0);
        idx_pulse();
        m_carry = 0; m_borrow = 0;
        chk("R13 stclr", 32'(held_o[7:5]), 0);
        set_mode(0, 0, 0, 0);
        idx_pulse();
        chk("R13 none count", 32'(count_o), 32'h21);
        chk("R13 none snap", 32'(snap_o), 32'h21);
        set_mode(0, 0, 2, 0);
        in_idx = 1'b1; @(negedge clk);
        m_cnt = '0; m_carry = 0; m_borrow = 0; m_frozen = 0;
        apply_ab(1'b0, 1'b1, "R13 idx high");
        apply_ab(1'b1, 1'b1, "R13 idx high step");
        chk("R13 no repeat", 32'(count_o), 1);
        in_idx = 1'b0;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule